// File: doc/BRIEF.md
# Speech Section Playback Controller

This block plays back one speech equation on behalf of a sequencer. An equation is an ordered list of sections: a head, sound sections, silence gaps and a tail. Each section carries its own sample-rate code, LED on/off bit and local repeat count. The whole list is wrapped in a global repeat count. The controller walks the list by presenting a section index. The sequencer answers with that section's descriptor in the same cycle.

For a sound section the controller issues one sample request per sample period to an external decoder. For a silence section it raises `mute` for the stated number of sample periods and issues no requests. Sample periods come from a fractional accumulator clocked by the system clock. This yields all four rates from one adder.

During play the controller drives two LED outputs. The LEDs are either steadily lit or flashing, and when flashing they run in phase or in opposite phase. The second LED appears only when the shared pin 4 is routed to it. The controller flags the final global pass for the sequencer's "last" condition. It pulses `done` on normal completion, and an abort input stops everything at once.

Top module: `speech_play`

## Requirements
- R1: After reset, and whenever idle, `busy`, `done`, `samp_req`, `mute`, `last_pass`, `led1` and `led2` are all low. A `start` pulse while idle begins play at section index 0, global pass 0.
- R2: Rate code `sec_rate` selects 0 = 4000 Hz, 1 = 4800 Hz, 2 = 6000 Hz, 3 = 8000 Hz. A sample period ends on each carry of an accumulator that adds the rate every clock modulo `CLK_HZ`. With `CLK_HZ` = 24000 the periods are 6, 5, 4 and 3 clocks, and the first period after start is full length.
- R3: A sound section (`sec_silence` = 0) lasts `sec_len`+1 sample periods and raises `samp_req` for exactly one clock in each period.
- R4: A silence section (`sec_silence` = 1) lasts `sec_len`+1 sample periods. During it `mute` is high and `samp_req` stays low.
- R5: Each section is played `sec_reps` times in a row before the index advances. A value of 0 counts as 1.
- R6: Sections 0 through `last_idx` are played `glob_cnt`+1 times. `last_pass` is high during every busy cycle of the final pass and during no other cycle.
- R7: On completion `done` is high for exactly one clock, and `busy` is low in that same clock.
- R8: With `mode_flash` = 0, `led1` is high exactly in the busy cycles whose current section has `sec_led` = 1.
- R9: With `mode_flash` = 1, the LED phase starts lit at start. It inverts every `CLK_HZ`/(2*`FLASH_HZ`) clocks (4000 clocks with the bench's 24000 Hz clock and 3 Hz flash).
- R10: `led2` is driven only when `pin4_trig` = 0 and `pin4_led2` = 1. Otherwise it stays low.
- R11: With `alt_flash` = 0, `led2` equals `led1` whenever pin 4 is routed to the LED. With `alt_flash` = 1 and flashing, `led2` is the inverse of `led1` during lit sections.
- R12: An `abort` clears `busy` and both LEDs at the next clock edge. No `done` pulse follows an abort.
- R13: A `start` pulse while busy has no effect on the running equation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an equation when idle |
| abort | input | 1 | Stop play immediately |
| glob_cnt | input | GR_W | Global passes minus one |
| last_idx | input | IDX_W | Index of the final (tail) section |
| sec_idx | output | IDX_W | Index of the section being played |
| sec_silence | input | 1 | Current section is a silence gap |
| sec_rate | input | 2 | Current section rate code |
| sec_led | input | 1 | Current section LED enable |
| sec_reps | input | LR_W | Current section local repeat count |
| sec_len | input | LEN_W | Current section length minus one, in sample periods |
| mode_flash | input | 1 | 1 = flash LEDs, 0 = steady |
| pin4_trig | input | 1 | Pin 4 used as a trigger input |
| pin4_led2 | input | 1 | Pin 4 used as LED2 (else stop output) when not a trigger |
| alt_flash | input | 1 | 1 = alternate flash, 0 = synchronous |
| busy | output | 1 | Equation in progress |
| last_pass | output | 1 | Final global pass in progress |
| samp_req | output | 1 | One-clock request for the next decoded sample |
| mute | output | 1 | Silence section in progress |
| done | output | 1 | One-clock completion pulse |
| led1 | output | 1 | LED 1 drive |
| led2 | output | 1 | LED 2 drive |

## Verification
A wrong repeat or index counter shows up as a wrong number of `samp_req` pulses or `mute` cycles, and as a `busy` span that is too long or too short. This is visible only when the equation ends, so each scenario compares totals after `done`. An accumulator fault stretches or shrinks every sample period, which changes the busy length within the first section. A stuck flash phase or a wrong routing term appears within one half period as a missing toggle or as `led2` disagreeing with `led1`.

// File: rtl/speech_play.sv
module speech_play #(
  parameter int CLK_HZ   = 3000000,
  parameter int FLASH_HZ = 3,
  parameter int IDX_W    = 4,
  parameter int LEN_W    = 17,
  parameter int GR_W     = 4,
  parameter int LR_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [GR_W-1:0]  glob_cnt,
  input  logic [IDX_W-1:0] last_idx,
  output logic [IDX_W-1:0] sec_idx,
  input  logic             sec_silence,
  input  logic [1:0]       sec_rate,
  input  logic             sec_led,
  input  logic [LR_W-1:0]  sec_reps,
  input  logic [LEN_W-1:0] sec_len,
  input  logic             mode_flash,
  input  logic             pin4_trig,
  input  logic             pin4_led2,
  input  logic             alt_flash,
  output logic             busy,
  output logic             last_pass,
  output logic             samp_req,
  output logic             mute,
  output logic             done,
  output logic             led1,
  output logic             led2
);
  localparam int HALF  = (CLK_HZ / (2 * FLASH_HZ) > 0) ? CLK_HZ / (2 * FLASH_HZ) : 1;
  localparam int FC_W  = $clog2(HALF + 1);
  localparam int ACC_W = $clog2(CLK_HZ + 8001) + 1;

  logic [ACC_W-1:0] acc, step, sum;
  logic [LEN_W-1:0] cnt;
  logic [LR_W-1:0]  lrep;
  logic [GR_W-1:0]  gpass, glob_r;
  logic [IDX_W-1:0] last_r;
  logic [FC_W-1:0]  fcnt;
  logic             ph;
  logic             tick, sec_end, rep_end, pass_end, all_end;

  always_comb begin
    case (sec_rate)
      2'd0:    step = ACC_W'(4000);
      2'd1:    step = ACC_W'(4800);
      2'd2:    step = ACC_W'(6000);
      default: step = ACC_W'(8000);
    endcase
  end

  assign sum      = acc + step;
  assign tick     = busy && (sum >= ACC_W'(CLK_HZ));
  assign sec_end  = tick && (cnt == sec_len);
  assign rep_end  = sec_end && ((LR_W+1)'(lrep) + 1'b1 >= (LR_W+1)'(sec_reps));
  assign pass_end = rep_end && (sec_idx == last_r);
  assign all_end  = pass_end && (gpass == glob_r);

  assign samp_req  = tick && !sec_silence;
  assign mute      = busy && sec_silence;
  assign last_pass = busy && (gpass == glob_r);

  wire led_en = busy && sec_led;
  wire led2_p = !pin4_trig && pin4_led2;
  assign led1 = led_en && (!mode_flash || ph);
  assign led2 = led_en && led2_p && (!mode_flash || (ph ^ alt_flash));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; acc <= '0; cnt <= '0; lrep <= '0;
      gpass <= '0; glob_r <= '0; last_r <= '0; sec_idx <= '0;
      fcnt <= '0; ph <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (start) begin
          busy <= 1'b1; acc <= '0; cnt <= '0; lrep <= '0; gpass <= '0;
          sec_idx <= '0; glob_r <= glob_cnt; last_r <= last_idx;
          fcnt <= '0; ph <= 1'b1;
        end
      end else begin
        acc <= tick ? sum - ACC_W'(CLK_HZ) : sum;
        if (fcnt == FC_W'(HALF - 1)) begin
          fcnt <= '0;
          ph   <= ~ph;
        end else begin
          fcnt <= fcnt + 1'b1;
        end
        if (tick) begin
          if (!sec_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!rep_end) begin
              lrep <= lrep + 1'b1;
            end else begin
              lrep <= '0;
              if (!pass_end) begin
                sec_idx <= sec_idx + 1'b1;
              end else begin
                sec_idx <= '0;
                if (all_end) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                end else begin
                  gpass <= gpass + 1'b1;
                end
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/speech_play_chk.sv
module speech_play_chk (
  input logic clk,
  input logic rst_n,
  input logic abort,
  input logic pin4_trig,
  input logic pin4_led2,
  input logic alt_flash,
  input logic busy,
  input logic last_pass,
  input logic samp_req,
  input logic done,
  input logic led1,
  input logic led2
);
  // R1
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!led1 && !led2 && !last_pass && !samp_req));
  // R12
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R10
  pin4_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin4_trig |-> !led2);
  // R11
  sync_led_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_flash && !pin4_trig && pin4_led2) |-> (led1 == led2));
  // R6
  last_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_pass |-> busy);
endmodule

bind speech_play speech_play_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .pin4_trig(pin4_trig),
  .pin4_led2(pin4_led2), .alt_flash(alt_flash), .busy(busy),
  .last_pass(last_pass), .samp_req(samp_req), .done(done),
  .led1(led1), .led2(led2)
);

// File: tb/speech_play_bench.sv
module speech_play_bench;
  localparam int PERIOD = 10;
  localparam int CLK_HZ = 24000;

  logic clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [3:0] glob_cnt = 0, last_idx = 0, sec_idx;
  logic sec_silence, sec_led;
  logic [1:0] sec_rate;
  logic [2:0] sec_reps;
  logic [16:0] sec_len;
  logic mode_flash = 0, pin4_trig = 0, pin4_led2 = 1, alt_flash = 0;
  logic busy, last_pass, samp_req, mute, done, led1, led2;

  logic        t_sil [16];
  logic [1:0]  t_rate[16];
  logic        t_led [16];
  logic [2:0]  t_reps[16];
  logic [16:0] t_len [16];

  always_comb begin
    sec_silence = t_sil[sec_idx];
    sec_rate    = t_rate[sec_idx];
    sec_led     = t_led[sec_idx];
    sec_reps    = t_reps[sec_idx];
    sec_len     = t_len[sec_idx];
  end

  speech_play #(.CLK_HZ(CLK_HZ)) u_speech_play (.*);

  always #(PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int c_busy, c_req, c_mute, c_last, c_done, c_l1, c_l2, c_tog, c_same, c_diff;
  logic p_busy = 0, p_l1 = 0;

  always @(negedge clk) begin
    if (busy) begin
      c_busy++;
      c_req  += int'(samp_req);
      c_mute += int'(mute);
      c_last += int'(last_pass);
      c_l1   += int'(led1);
      c_l2   += int'(led2);
      if (led1 == led2) c_same++; else c_diff++;
      if (p_busy && led1 != p_l1) c_tog++;
    end
    c_done += int'(done);
    p_busy = busy;
    p_l1   = led1;
  end

  task automatic clr();
    c_busy = 0; c_req = 0; c_mute = 0; c_last = 0; c_done = 0;
    c_l1 = 0; c_l2 = 0; c_tog = 0; c_same = 0; c_diff = 0;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sec(int i, logic sil, int rate, logic led, int reps, int len);
    t_sil[i] = sil; t_rate[i] = 2'(rate); t_led[i] = led;
    t_reps[i] = 3'(reps); t_len[i] = 17'(len);
  endtask

  task automatic run();
    clr();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 leds", int'(led1 | led2), 0);
    chk("R1 req/mute/done/last", int'(samp_req | mute | done | last_pass), 0);
  endtask

  task automatic t_single();
    sec(0, 0, 3, 1, 1, 9); last_idx = 0; glob_cnt = 0;
    run();
    chk("R3 requests", c_req, 10);
    chk("R2 rate3 cycles", c_busy, 30);
    chk("R7 done pulses", c_done, 1);
  endtask

  task automatic t_local();
    sec(0, 0, 0, 1, 3, 3); last_idx = 0; glob_cnt = 0;
    run();
    chk("R5 requests", c_req, 12);
    chk("R2 rate0 cycles", c_busy, 72);
    sec(0, 0, 3, 1, 0, 3);
    run();
    chk("R5 zero reps as one", c_req, 4);
  endtask

  task automatic t_mixed();
    sec(0, 0, 1, 1, 1, 4); sec(1, 0, 0, 1, 1, 1); last_idx = 1; glob_cnt = 0;
    run();
    chk("R2 mixed rate cycles", c_busy, 37);
    chk("R3 mixed requests", c_req, 7);
  endtask

  task automatic t_global();
    sec(0, 0, 2, 1, 2, 1); sec(1, 1, 2, 1, 1, 4); last_idx = 1; glob_cnt = 2;
    run();
    chk("R6 total cycles", c_busy, 108);
    chk("R6 requests", c_req, 12);
    chk("R4 mute cycles", c_mute, 60);
    chk("R6 last_pass cycles", c_last, 36);
    chk("R7 done pulses", c_done, 1);
    glob_cnt = 0;
  endtask

  task automatic t_steady();
    sec(0, 0, 3, 1, 1, 9); sec(1, 0, 3, 0, 1, 9); last_idx = 1;
    mode_flash = 0; pin4_trig = 0; pin4_led2 = 1;
    run();
    chk("R8 led1 lit cycles", c_l1, 30);
    chk("R10 led2 routed", c_l2, 30);
    pin4_trig = 1;
    run();
    chk("R10 led2 trigger pin", c_l2, 0);
    pin4_trig = 0; pin4_led2 = 0;
    run();
    chk("R10 led2 stop pin", c_l2, 0);
    pin4_led2 = 1;
  endtask

  task automatic t_flash();
    sec(0, 0, 3, 1, 1, 8999); last_idx = 0; mode_flash = 1; alt_flash = 0;
    run();
    chk("R9 sync toggles", c_tog, 6);
    chk("R11 sync differ cycles", c_diff, 0);
    alt_flash = 1;
    run();
    chk("R9 alt toggles", c_tog, 6);
    chk("R11 alt same cycles", c_same, 0);
    alt_flash = 0; mode_flash = 0;
  endtask

  task automatic t_abort();
    int r0;
    sec(0, 0, 3, 1, 1, 999); last_idx = 0; clr();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (50) @(negedge clk);
    abort = 1;
    @(negedge clk) abort = 0;
    chk("R12 busy cleared", int'(busy), 0);
    chk("R12 leds off", int'(led1 | led2), 0);
    r0 = c_req;
    repeat (20) @(negedge clk);
    chk("R12 no requests after abort", c_req, r0);
    chk("R12 no done", c_done, 0);
  endtask

  task automatic t_restart();
    sec(0, 0, 3, 1, 1, 9); last_idx = 0; clr();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (10) @(negedge clk);
    start = 1;
    @(negedge clk) start = 0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R13 requests", c_req, 10);
    chk("R13 cycles", c_busy, 30);
    chk("R13 done pulses", c_done, 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) sec(i, 0, 3, 1, 1, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_local();
    t_mixed();
    t_global();
    t_steady();
    t_flash();
    t_abort();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule